// File: doc/BRIEF.md
# Bidirectional GPIO Port with Weak Pull-ups

This block controls an eight-pin general-purpose I/O port. Software reaches four registers through a small synchronous register interface: a direction register, a port data register, an output latch register and a pad configuration register. From the contents of these registers the block produces three values for every pin: an output value, an output enable and a weak pull-up enable. A pad driver outside the block uses these three values.

Pad input levels pass through a two-stage synchronizer before a read of the port data register returns them. Each pin also has an override input. When the override is active, an alternate peripheral decides the pin's direction and output value, and the direction register has no effect on that pin.

The weak pull-ups are gated in two ways. One bit in the pad configuration register switches off the pull-ups on all pins at once. Separately, any pin that is being driven as an output has its pull-up switched off automatically.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the latch reads 0x00, and the pad configuration register reads 0x40 (pull-ups disabled). Every pin_oe and pin_pu bit is 0.
- R2: Direction bit n = 0 drives pin n, with pin_oe[n]=1 and pin_out[n] equal to latch bit n. Direction bit n = 1 makes pin n an input, with pin_oe[n]=0.
- R3: Address 1 (port data) and address 2 (latch) both write the output latch. A read of address 2 returns the latch contents.
- R4: Bit 6 of the pad configuration register (address 3) is the global pull-up disable. While it is 1, every pin_pu bit is 0. While it is 0, each pin that is not driving has pin_pu=1. The other bits of this register are not stored and read as 0.
- R5: A driving pin (pin_oe[n]=1) always has pin_pu[n]=0, whatever the global disable bit holds.
- R6: While alt_en[n]=1, pin_oe[n] follows alt_oe[n] and pin_out[n] follows alt_out[n]. The direction bit of that pin is ignored. The pull-up gating of R5 then uses this effective output enable.
- R7: A read of address 1 returns the pad levels after a two-flop synchronizer. A pad change made just before clock edge k becomes visible in rdata after edge k+2, and not before.
- R8: rdata is registered. It shows the register selected by addr one clock edge after addr is presented. Address 0 selects the direction register.
- R9: A write to one address leaves the contents of the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 2 | Register select: 0 direction, 1 port data, 2 latch, 3 pad configuration |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad input levels |
| alt_en | input | 8 | Per-pin peripheral override enable |
| alt_oe | input | 8 | Peripheral output enable for overridden pins |
| alt_out | input | 8 | Peripheral output data for overridden pins |
| pin_out | output | 8 | Output value to each pad |
| pin_oe | output | 8 | Output enable to each pad |
| pin_pu | output | 8 | Weak pull-up enable to each pad |

## Verification
The assertions check the following on every cycle:
- a driving pin never has its pull-up enabled;
- the global disable bit blocks all pull-ups;
- overridden pins follow the peripheral's direction;
- the synchronized value trails the pad by exactly two cycles;
- read data appears one cycle after the address;
- the registers hold their reset values while the internal reset is asserted.

Other behaviour can only be shown by the bench's scenarios. These are: port-address writes landing in the latch; the read-back of unstored configuration bits as 0; writes leaving the other registers untouched; and the exact edge at which a pad change first shows in a read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned PUD_BIT = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_PORT = 2'd1,
    REG_LAT  = 2'd2,
    REG_PAD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_in;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pad_sync,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q,
  output logic              pud_q,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] dir_d, lat_d, rdata_d, rdata_q;
  logic             pud_d;
  logic             dir_en, lat_en, pud_en;
  logic [WIDTH-1:0] pad_view;
  reg_sel_e         sel;

  always_comb begin
    sel    = reg_sel_e'(addr);
    dir_en = wr_en && (sel == REG_DIR);
    lat_en = wr_en && ((sel == REG_PORT) || (sel == REG_LAT));
    pud_en = wr_en && (sel == REG_PAD);
    dir_d  = dir_en ? wdata : dir_q;
    lat_d  = lat_en ? wdata : lat_q;
    pud_d  = pud_en ? wdata[PUD_BIT] : pud_q;
  end

  always_comb begin
    pad_view          = '0;
    pad_view[PUD_BIT] = pud_q;
    unique case (sel)
      REG_DIR:  rdata_d = dir_q;
      REG_PORT: rdata_d = pad_sync;
      REG_LAT:  rdata_d = lat_q;
      REG_PAD:  rdata_d = pad_view;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      lat_q   <= '0;
      pud_q   <= 1'b1;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      lat_q   <= lat_d;
      pud_q   <= pud_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic             pud_q,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_oe,
  input  logic [WIDTH-1:0] alt_out,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_pu
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic eff_oe;
      logic eff_out;
      always_comb begin
        if (alt_en[i]) begin
          eff_oe  = alt_oe[i];
          eff_out = alt_out[i];
        end else begin
          eff_oe  = ~dir_q[i];
          eff_out = lat_q[i];
        end
      end
      assign pin_oe[i]  = eff_oe;
      assign pin_out[i] = eff_out;
      assign pin_pu[i]  = ~pud_q & ~eff_oe;
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [PORT_W-1:0] pad_in,
  input  logic [PORT_W-1:0] alt_en,
  input  logic [PORT_W-1:0] alt_oe,
  input  logic [PORT_W-1:0] alt_out,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu
);
  logic              rst_sync_n;
  logic [PORT_W-1:0] sync_q;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] lat_q;
  logic              pud_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(PORT_W), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (sync_q)
  );

  gpio_regs #(.WIDTH(PORT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .pad_sync (sync_q),
    .dir_q    (dir_q),
    .lat_q    (lat_q),
    .pud_q    (pud_q),
    .rdata    (rdata)
  );

  gpio_pin_ctrl #(.WIDTH(PORT_W)) u_pins (
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .pud_q   (pud_q),
    .alt_en  (alt_en),
    .alt_oe  (alt_oe),
    .alt_out (alt_out),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_pu  (pin_pu)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [PORT_W-1:0] rdata,
  input logic [PORT_W-1:0] pad_in,
  input logic [PORT_W-1:0] alt_en,
  input logic [PORT_W-1:0] alt_oe,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_pu,
  input logic [PORT_W-1:0] sync_q,
  input logic [PORT_W-1:0] dir_q,
  input logic [PORT_W-1:0] lat_q,
  input logic              pud_q
);
  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         live_cnt <= '0;
    else if (rst_sync_n && live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (dir_q == '1 && lat_q == '0 && pud_q));

  p_pu_off_driving_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  p_global_pud_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pud_q |-> (pin_pu == '0));

  p_alt_owns_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ alt_oe) & alt_en) == '0);

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2) |-> (sync_q == $past(pad_in, 2)));

  p_read_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && live_cnt >= 2'd1 && addr == REG_DIR && !wr_en) |=> (rdata == $past(dir_q)));
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .rdata      (rdata),
  .pad_in     (pad_in),
  .alt_en     (alt_en),
  .alt_oe     (alt_oe),
  .pin_oe     (pin_oe),
  .pin_pu     (pin_pu),
  .sync_q     (sync_q),
  .dir_q      (dir_q),
  .lat_q      (lat_q),
  .pud_q      (pud_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] alt_en = 8'h00;
  logic [7:0] alt_oe = 8'h00;
  logic [7:0] alt_out = 8'h00;
  logic [7:0] pin_out, pin_oe, pin_pu;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  bit    rd_issue = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .alt_en(alt_en), .alt_oe(alt_oe),
    .alt_out(alt_out), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    rd_issue = 1'b1;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares registered read data one edge after the address
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rd_issue) begin
        item_t it;
        rd_issue = 1'b0;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_pu", pin_pu, 8'h00);
    rd(2'd0, 8'hFF, "R1 dir reset");
    rd(2'd2, 8'h00, "R1 latch reset");
    rd(2'd3, 8'h40, "R1 padcfg reset");
    settle();

    // R2 direction / R3 port-address write to latch
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'hA5);
    check("R2 pin_oe", pin_oe, 8'hF0);
    check("R2 pin_out", pin_out, 8'hA5);
    rd(2'd2, 8'hA5, "R3 latch via port write");
    rd(2'd0, 8'h0F, "R8 dir read");
    settle();

    // R4 global pull-up disable, R5 forced off on outputs
    check("R4 pu while disabled", pin_pu, 8'h00);
    wr(2'd3, 8'h00);
    check("R4 pu enabled", pin_pu, 8'h0F);
    check("R5 no pu on drivers", pin_pu & pin_oe, 8'h00);
    wr(2'd3, 8'hBF);
    check("R4 pu other bits ignored", pin_pu, 8'h0F);
    rd(2'd3, 8'h00, "R4 padcfg unstored bits");
    settle();
    wr(2'd0, 8'h00);
    check("R5 all outputs no pu", pin_pu, 8'h00);
    wr(2'd0, 8'h0F);

    // R3 latch address write, R9 isolation
    wr(2'd2, 8'h3C);
    rd(2'd2, 8'h3C, "R3 latch write");
    wr(2'd2, 8'h81);
    rd(2'd2, 8'h81, "R3 latch rewrite");
    rd(2'd0, 8'h0F, "R9 dir untouched");
    rd(2'd3, 8'h00, "R9 padcfg untouched");
    settle();

    // R6 peripheral override
    @(negedge clk);
    alt_en = 8'h13; alt_oe = 8'h01; alt_out = 8'h02;
    #1;
    check("R6 oe", pin_oe, 8'hE1);
    check("R6 out", pin_out, 8'h82);
    check("R6 pu", pin_pu, 8'h1E);
    @(negedge clk);
    alt_en = 8'h00;
    #1;
    check("R6 release", pin_oe, 8'hF0);

    // R4 re-disable
    wr(2'd3, 8'h40);
    check("R4 pu disabled again", pin_pu, 8'h00);

    // R7 synchronizer latency
    @(negedge clk);
    pad_in = 8'h5A;
    addr = 2'd1;
    sb_q.push_back('{exp: 8'h00, tag: "R7 edge+1 old"});
    rd_issue = 1'b1;
    rd(2'd1, 8'h00, "R7 edge+2 old");
    rd(2'd1, 8'h5A, "R7 edge+3 new");
    settle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule